// File: doc/BRIEF.md
# Zero-Turnaround Late-Write Synchronous SRAM

This block is a synchronous static memory with a command front end that takes a new read, write or deselect on every enabled rising clock edge. Reads and writes may follow each other in any order with no idle cycle in between. This works because write data trails its command. The data for a write is sampled one or two enabled edges after the command, in the slot where a read issued at the same time would have driven the bus. Read data and write data therefore never meet on the shared data lines.

A static timing select picks one of two modes. In pipelined mode, read data passes through an output register and appears one edge later. In flow-through mode, the registered address drives the array directly. Writes are masked per 9-bit byte lane. Three chip-enable inputs must all be in their active state for a command to count. A clock enable freezes every register, including the array. An output enable gates the data drivers asynchronously. The storage is a plain register array, 36 bits wide and 64 words deep by default.

Top module: `zt_lw_sram`

## Requirements
- R1: While `rst_n` is low, and after it is released before any read, `q_drv` is 0 and `q_out` is all zeros.
- R2: With `mode_flow`=0, a read sampled at enabled edge n drives `q_drv`=1 and the word on `q_out` from edge n+1 until the next enabled edge.
- R3: With `mode_flow`=1, a read sampled at enabled edge n drives `q_drv`=1 and the word on `q_out` from edge n until the next enabled edge.
- R4: A write sampled at enabled edge n takes `d_in` at the second following enabled edge when `mode_flow`=0, and at the first following enabled edge when `mode_flow`=1. `d_in` at every other edge is ignored.
- R5: Lane b is bits [9b+8:9b]. A write stores lane b only when `bw_n[b]`=0, so `bw_n`=4'b1111 stores nothing and 4'b0000 stores the whole word.
- R6: Reads and writes to any addresses may alternate on consecutive enabled edges, and every read returns correct data.
- R7: A read returns every write whose data has been sampled by the edge at which the read data appears. This includes a write whose data arrives on that same edge, merged lane by lane with the older contents.
- R8: A command counts only when `ce_a_n`=0, `ce_b`=1 and `ce_c_n`=0. Otherwise it is a deselect: nothing is stored and nothing is read.
- R9: An edge with `clk_en`=0 changes no state. The array, the command pipeline, the outputs and the sampling of `d_in` all hold.
- R10: `oe_n`=1 forces `q_drv` to 0 and `q_out` to zero at once, without waiting for a clock edge.
- R11: A deselect or write turns `q_drv` to 0 in the same slot where a read issued at that edge would have driven data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of command and output state |
| mode_flow | input | 1 | Static timing select: 1 flow-through, 0 pipelined |
| clk_en | input | 1 | 1 lets the edge advance state, 0 holds everything |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | 0 write command, 1 read command |
| addr | input | ADDR_W | Word address |
| bw_n | input | NBYTES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| d_in | input | NBYTES*BYTE_W | Late write data |
| q_out | output | NBYTES*BYTE_W | Read data, zero when not driven |
| q_drv | output | 1 | 1 when the data lines are driven (0 models high impedance) |

## Verification
The bench goes after a read of an address whose partial-lane write lands on the very edge the read data is produced. A design that skipped the merge from the incoming data would return the stale word. It also holds the clock enable low between a write command and its data slot while junk sits on `d_in`. A design that sampled data on held edges, or counted them as pipeline steps, would store the junk or shift the write slot. Each of the three chip-enable inputs is tested alone with a write and a read. A design that decoded one of them wrongly would store data or drive the bus. Every check runs in both timing modes, so a one-cycle slip in either data latency shows up as a wrong word in the next slot.

// File: rtl/zt_lw_pkg.sv
package zt_lw_pkg;
  localparam int DEF_ADDR_W = 6;
  localparam int DEF_NBYTES = 4;
  localparam int DEF_BYTE_W = 9;

  typedef enum logic {
    MODE_PIPE = 1'b0,
    MODE_FLOW = 1'b1
  } lw_mode_e;
endpackage

// File: rtl/zt_lw_cmd_pipe.sv
// Two-deep history of accepted commands; advances only on enabled edges.
module zt_lw_cmd_pipe #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              in_vld,
  input  logic              in_wr,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [NBYTES-1:0] in_bw_n,
  output logic              s1_vld,
  output logic              s1_wr,
  output logic [ADDR_W-1:0] s1_addr,
  output logic [NBYTES-1:0] s1_bw_n,
  output logic              s2_vld,
  output logic              s2_wr,
  output logic [ADDR_W-1:0] s2_addr,
  output logic [NBYTES-1:0] s2_bw_n
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_wr   <= 1'b0;
      s1_addr <= '0;
      s1_bw_n <= '1;
      s2_vld  <= 1'b0;
      s2_wr   <= 1'b0;
      s2_addr <= '0;
      s2_bw_n <= '1;
    end else if (clk_en) begin
      s1_vld  <= in_vld;
      s1_wr   <= in_wr;
      s1_addr <= in_addr;
      s1_bw_n <= in_bw_n;
      s2_vld  <= s1_vld;
      s2_wr   <= s1_wr;
      s2_addr <= s1_addr;
      s2_bw_n <= s1_bw_n;
    end
  end
endmodule

// File: rtl/zt_lw_array.sv
// Storage split into independent byte lanes, one write port, one read port.
module zt_lw_array #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 9
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [NBYTES-1:0]        wr_bw_n,
  input  logic [NBYTES*BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [NBYTES*BYTE_W-1:0] rd_data
);
  localparam int NWORDS = 1 << ADDR_W;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] lane_mem [NWORDS];
    logic              lane_we;

    assign lane_we = wr_en && !wr_bw_n[b];

    always_ff @(posedge clk) begin
      if (lane_we) lane_mem[wr_addr] <= wr_data[b*BYTE_W +: BYTE_W];
    end

    assign rd_data[b*BYTE_W +: BYTE_W] = lane_mem[rd_addr];
  end
endmodule

// File: rtl/zt_lw_out_stage.sv
// Output register (pipelined), forwarding merge, mode select, output enable.
module zt_lw_out_stage #(
  parameter int NBYTES = 4,
  parameter int BYTE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clk_en,
  input  logic                     flow_sel,
  input  logic                     oe_n,
  input  logic                     s1_vld,
  input  logic                     s1_wr,
  input  logic                     fwd_hit,
  input  logic [NBYTES-1:0]        fwd_bw_n,
  input  logic [NBYTES*BYTE_W-1:0] fwd_data,
  input  logic [NBYTES*BYTE_W-1:0] arr_data,
  output logic [NBYTES*BYTE_W-1:0] q_out,
  output logic                     q_drv
);
  localparam int DATA_W = NBYTES * BYTE_W;

  // Overlay the lanes of new_w whose active-low enable is 0 onto old_w.
  function automatic logic [DATA_W-1:0] lane_merge(
    input logic [DATA_W-1:0] old_w,
    input logic [DATA_W-1:0] new_w,
    input logic [NBYTES-1:0] take_n
  );
    logic [DATA_W-1:0] r;
    r = old_w;
    for (int b = 0; b < NBYTES; b++) begin
      if (!take_n[b]) r[b*BYTE_W +: BYTE_W] = new_w[b*BYTE_W +: BYTE_W];
    end
    return r;
  endfunction

  logic              rd_slot;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] pipe_q;
  logic              pipe_drv;
  logic              sel_drv;
  logic [DATA_W-1:0] sel_q;

  assign rd_slot = s1_vld && !s1_wr;
  assign merged  = lane_merge(arr_data, fwd_data, fwd_hit ? fwd_bw_n : '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe_drv <= 1'b0;
      pipe_q   <= '0;
    end else if (clk_en) begin
      pipe_drv <= rd_slot;
      pipe_q   <= merged;
    end
  end

  assign sel_drv = flow_sel ? rd_slot  : pipe_drv;
  assign sel_q   = flow_sel ? arr_data : pipe_q;
  assign q_drv   = sel_drv && !oe_n;
  assign q_out   = q_drv ? sel_q : '0;
endmodule

// File: rtl/zt_lw_sram.sv
module zt_lw_sram
  import zt_lw_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int NBYTES = DEF_NBYTES,
  parameter int BYTE_W = DEF_BYTE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mode_flow,
  input  logic                     clk_en,
  input  logic                     ce_a_n,
  input  logic                     ce_b,
  input  logic                     ce_c_n,
  input  logic                     we_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NBYTES-1:0]        bw_n,
  input  logic                     oe_n,
  input  logic [NBYTES*BYTE_W-1:0] d_in,
  output logic [NBYTES*BYTE_W-1:0] q_out,
  output logic                     q_drv
);
  localparam int DATA_W = NBYTES * BYTE_W;

  lw_mode_e mode;
  assign mode = lw_mode_e'(mode_flow);

  // Named command events (also observed by the checker).
  logic chip_sel;
  logic rd_issue;
  logic desel_issue;
  assign chip_sel    = !ce_a_n && ce_b && !ce_c_n;
  assign rd_issue    = rst_n && clk_en && chip_sel && we_n;
  assign desel_issue = rst_n && clk_en && !chip_sel;

  logic              s1_vld, s1_wr, s2_vld, s2_wr;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [NBYTES-1:0] s1_bw_n, s2_bw_n;

  zt_lw_cmd_pipe #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .clk_en  (clk_en),
    .in_vld  (chip_sel),
    .in_wr   (!we_n),
    .in_addr (addr),
    .in_bw_n (bw_n),
    .s1_vld  (s1_vld),
    .s1_wr   (s1_wr),
    .s1_addr (s1_addr),
    .s1_bw_n (s1_bw_n),
    .s2_vld  (s2_vld),
    .s2_wr   (s2_wr),
    .s2_addr (s2_addr),
    .s2_bw_n (s2_bw_n)
  );

  // Late-write commit slot: one step back when flow-through, two when pipelined.
  logic              flow_sel;
  logic              commit_we;
  logic [ADDR_W-1:0] commit_addr;
  logic [NBYTES-1:0] commit_bw_n;
  assign flow_sel    = (mode == MODE_FLOW);
  assign commit_we   = clk_en && (flow_sel ? (s1_vld && s1_wr) : (s2_vld && s2_wr));
  assign commit_addr = flow_sel ? s1_addr : s2_addr;
  assign commit_bw_n = flow_sel ? s1_bw_n : s2_bw_n;

  logic [DATA_W-1:0] arr_data;

  zt_lw_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_arr (
    .clk     (clk),
    .wr_en   (commit_we),
    .wr_addr (commit_addr),
    .wr_bw_n (commit_bw_n),
    .wr_data (d_in),
    .rd_addr (s1_addr),
    .rd_data (arr_data)
  );

  // Pipelined read of s1 lands on the same edge that commits s2: forward it.
  logic fwd_hit;
  assign fwd_hit = !flow_sel && s2_vld && s2_wr && (s2_addr == s1_addr);

  zt_lw_out_stage #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .flow_sel (flow_sel),
    .oe_n     (oe_n),
    .s1_vld   (s1_vld),
    .s1_wr    (s1_wr),
    .fwd_hit  (fwd_hit),
    .fwd_bw_n (s2_bw_n),
    .fwd_data (d_in),
    .arr_data (arr_data),
    .q_out    (q_out),
    .q_drv    (q_drv)
  );
endmodule

// File: rtl/zt_lw_sram_chk.sv
module zt_lw_sram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_flow,
  input logic              clk_en,
  input logic              oe_n,
  input logic              rd_issue,
  input logic              desel_issue,
  input logic              commit_we,
  input logic              q_drv,
  input logic [DATA_W-1:0] q_out
);
  AST_OE_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!q_drv && q_out == '0)); // R10

  AST_FLOW_READ_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_flow && $past(rd_issue) && !oe_n) |-> q_drv); // R3

  AST_PIPE_READ_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_flow && $past(rd_issue, 2) && $past(clk_en) && !oe_n) |-> q_drv); // R2

  AST_FLOW_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_flow && $past(desel_issue)) |-> !q_drv); // R11

  AST_PIPE_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_flow && $past(desel_issue, 2) && $past(clk_en)) |-> !q_drv); // R11

  AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit_we |-> clk_en); // R9

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clk_en) && $stable(oe_n)) |-> ($stable(q_drv) && $stable(q_out))); // R9
endmodule

bind zt_lw_sram zt_lw_sram_chk #(.DATA_W(NBYTES*BYTE_W)) i_zt_lw_sram_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_flow   (mode_flow),
  .clk_en      (clk_en),
  .oe_n        (oe_n),
  .rd_issue    (rd_issue),
  .desel_issue (desel_issue),
  .commit_we   (commit_we),
  .q_drv       (q_drv),
  .q_out       (q_out)
);

// File: tb/test_zt_lw_sram.sv
module test_zt_lw_sram;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int BW = 9;
  localparam int DW = NB * BW;
  localparam logic [2:0] SEL  = 3'b010;   // {ce_a_n, ce_b, ce_c_n} all active
  localparam logic [2:0] IDLE = 3'b110;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_flow = 1'b0;
  logic          clk_en = 1'b1;
  logic          ce_a_n = 1'b1, ce_b = 1'b1, ce_c_n = 1'b0;
  logic          we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [NB-1:0] bw_n = '1;
  logic          oe_n = 1'b0;
  logic [DW-1:0] d_in = '0;
  logic [DW-1:0] q_out;
  logic          q_drv;

  zt_lw_sram i_zt_lw_sram (
    .clk(clk), .rst_n(rst_n), .mode_flow(mode_flow), .clk_en(clk_en),
    .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n), .we_n(we_n),
    .addr(addr), .bw_n(bw_n), .oe_n(oe_n), .d_in(d_in),
    .q_out(q_out), .q_drv(q_drv)
  );

  always #10 clk = ~clk;   // 50 MHz

  int checks = 0;
  int errors = 0;

  // Reference model: command history and memory with late-write timing.
  typedef struct {
    bit            vld;
    bit            wr;
    logic [AW-1:0] a;
    logic [NB-1:0] bw;
    logic [DW-1:0] d;
  } cmd_t;

  cmd_t          h1, h2;
  logic [DW-1:0] ref_mem [64];
  bit            exp_drv;
  logic [DW-1:0] exp_q;
  int            junk = 0;

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return {6'(a), 30'(salt * 32'h0133_7F1 + a * 32'h5A3)};
  endfunction

  task automatic check(input string tag, input bit ok, input logic [DW:0] act, input logic [DW:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_out(input string tag);
    bit            e_drv;
    logic [DW-1:0] e_q;
    e_drv = exp_drv && !oe_n;
    e_q   = e_drv ? exp_q : '0;
    check(tag, (q_drv === e_drv) && (q_out === e_q), {q_drv, q_out}, {e_drv, e_q});
  endtask

  // One clock: drive at negedge, model the edge, check at next negedge.
  task automatic cyc(input bit en, input logic [2:0] ce, input bit wr, input int a,
                     input logic [NB-1:0] bw, input logic [DW-1:0] wd, input string tag);
    cmd_t c, cm, co;
    cm = mode_flow ? h1 : h2;
    clk_en = en;
    {ce_a_n, ce_b, ce_c_n} = ce;
    we_n = !wr;
    addr = AW'(a);
    bw_n = bw;
    junk++;
    d_in = (en && cm.vld && cm.wr) ? cm.d : {4'hC, 32'(junk * 32'h9E37_79B9)};
    @(posedge clk);
    if (en) begin
      if (cm.vld && cm.wr)
        for (int b = 0; b < NB; b++)
          if (!cm.bw[b]) ref_mem[cm.a][b*BW +: BW] = cm.d[b*BW +: BW];
      c.vld = (ce == SEL); c.wr = wr; c.a = AW'(a); c.bw = bw; c.d = wd;
      co = mode_flow ? c : h1;
      exp_drv = co.vld && !co.wr;
      exp_q = ref_mem[co.a];
      h2 = h1;
      h1 = c;
    end
    @(negedge clk);
    check_out(tag);
  endtask

  task automatic wr_c(input int a, input logic [NB-1:0] bw, input logic [DW-1:0] wd, input string tag);
    cyc(1'b1, SEL, 1'b1, a, bw, wd, tag);
  endtask
  task automatic rd_c(input int a, input string tag);
    cyc(1'b1, SEL, 1'b0, a, '1, '0, tag);
  endtask
  task automatic idle_c(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b1, IDLE, 1'b0, 0, '1, '0, tag);
  endtask

  function automatic string rd_tag();
    return mode_flow ? "R3" : "R2";
  endfunction

  task automatic do_reset(input bit flow);
    @(negedge clk);
    rst_n = 1'b0;
    mode_flow = flow;
    clk_en = 1'b1;
    {ce_a_n, ce_b, ce_c_n} = IDLE;
    oe_n = 1'b0;
    h1 = '{default: 0};
    h2 = '{default: 0};
    exp_drv = 1'b0;
    exp_q = '0;
    repeat (3) @(negedge clk);
    check("R1 reset", (q_drv === 1'b0) && (q_out === '0), {q_drv, q_out}, '0);
    rst_n = 1'b1;
    idle_c(1, "R1");
  endtask

  task automatic t_fill();
    for (int a = 0; a < 64; a++) wr_c(a, 4'b0000, pat(a, 1), "R4");
    idle_c(2, "R4");
  endtask

  task automatic t_reads();
    for (int a = 0; a < 8; a++) rd_c(a * 9 % 64, rd_tag());
    idle_c(2, rd_tag());
  endtask

  task automatic t_alternate(input int salt);
    for (int i = 0; i < 6; i++) begin
      wr_c(10 + i, 4'b0000, pat(10 + i, salt), "R6");
      rd_c(10 + i, "R6");          // read of the word just written
      rd_c(9 + i, "R6");
    end
    idle_c(2, "R6");
  endtask

  task automatic t_bytes(input int salt);
    wr_c(20, 4'b1110, pat(20, salt), "R5");
    wr_c(21, 4'b0101, pat(21, salt), "R5");
    wr_c(22, 4'b1111, pat(22, salt), "R5");   // writes nothing
    wr_c(23, 4'b0111, pat(23, salt), "R5");
    idle_c(2, "R5");
    for (int a = 20; a < 24; a++) rd_c(a, "R5");
    idle_c(2, "R5");
  endtask

  task automatic t_forward(input int salt);
    wr_c(30, 4'b1010, pat(30, salt), "R7");
    rd_c(30, "R7");
    wr_c(31, 4'b0110, pat(31, salt), "R7");
    rd_c(31, "R7");
    rd_c(31, "R7");
    wr_c(32, 4'b0000, pat(32, salt), "R7");
    wr_c(32, 4'b1100, pat(33, salt), "R7");
    rd_c(32, "R7");
    rd_c(32, "R7");
    idle_c(2, "R7");
  endtask

  task automatic t_desel(input int salt);
    cyc(1'b1, 3'b110, 1'b1, 40, 4'b0000, pat(40, salt), "R8");
    cyc(1'b1, 3'b000, 1'b1, 41, 4'b0000, pat(41, salt), "R8");
    cyc(1'b1, 3'b011, 1'b1, 42, 4'b0000, pat(42, salt), "R8");
    cyc(1'b1, 3'b110, 1'b0, 40, '1, '0, "R11");
    cyc(1'b1, 3'b000, 1'b0, 41, '1, '0, "R11");
    rd_c(40, "R8");
    cyc(1'b1, 3'b011, 1'b0, 42, '1, '0, "R11");
    rd_c(41, "R8");
    rd_c(42, "R8");
    idle_c(2, "R11");
  endtask

  task automatic t_hold(input int salt);
    wr_c(50, 4'b0000, pat(50, salt), "R9");
    repeat (3) cyc(1'b0, SEL, 1'b1, 51, 4'b0000, pat(51, salt + 7), "R9");
    rd_c(50, "R9");
    repeat (3) cyc(1'b0, SEL, 1'b0, 52, '1, '0, "R9");
    wr_c(50, 4'b0011, pat(53, salt), "R9");
    cyc(1'b0, IDLE, 1'b0, 0, '1, '0, "R9");
    rd_c(50, "R9");
    cyc(1'b0, IDLE, 1'b0, 0, '1, '0, "R9");
    idle_c(2, "R9");
    rd_c(51, "R9");
    idle_c(2, "R9");
  endtask

  task automatic t_oe();
    rd_c(3, rd_tag());
    rd_c(4, rd_tag());
    oe_n = 1'b1;
    #1;
    check("R10", (q_drv === 1'b0) && (q_out === '0), {q_drv, q_out}, '0);
    oe_n = 1'b0;
    #1;
    check_out("R10");
    idle_c(2, "R10");
  endtask

  task automatic run_mode(input bit flow, input int salt);
    do_reset(flow);
    if (salt == 2) t_fill();
    t_reads();
    t_alternate(salt);
    t_bytes(salt);
    t_forward(salt);
    t_desel(salt);
    t_hold(salt);
    t_oe();
  endtask

  initial begin
    for (int a = 0; a < 64; a++) ref_mem[a] = '0;
    run_mode(1'b0, 2);
    run_mode(1'b1, 5);
    run_mode(1'b0, 9);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule